// File: doc/BRIEF.md
# Serial Transmit Framing Sequencer

This block runs the transmit side of a serial packet port. An upstream source holds a transmit enable active for as long as it has payload to send. The block answers by putting out a preamble of fixed ones and then a 32-bit header assembled from four byte registers: a signal byte, a service byte and a 16-bit length split into low and high bytes. After that it pulls the payload in one bit at a time by pulsing a gated payload clock. It sends each captured bit one bit period later on the serial output that feeds the modulator. When the source lets the enable fall, the block sends zero flush bits for two microseconds and then goes quiet.

All timing is counted in system clocks. `CLK_PER_US` gives the clocks per microsecond and `BIT_DIV` gives the clocks per serial bit. Two idle thresholds are derived from `CLK_PER_US`. The first, the ceiling of 2.22 µs, arms the block for a new frame. The second, the ceiling of 4.22 µs, raises a one-clock modulator reset pulse. The ready, enable and payload clock pins each have an active level that a polarity register sets. The source must keep the payload length a multiple of the bits per symbol used downstream. The block does not police this.

Top module: `tx_frame_seq`

## Requirements
- R1: When the enable is active and the block is armed and idle, `tx_on` is high from the next clock edge and the preamble starts with bit period phase zero.
- R2: The preamble is `PRE_LEN` serial bits, each of value 1. Every serial bit, preamble or otherwise, holds `tx_bit` steady for `BIT_DIV` clocks.
- R3: Right after the preamble come 32 header bits, least significant bit first. The order is the signal byte (register address 0), the service byte (address 1), the length low byte (address 2) and then the length high byte (address 3).
- R4: The payload clock is active for the second half of a bit period, that is clocks `BIT_DIV/2` to `BIT_DIV-1` of the period. It pulses only in the last header bit and in payload bits, and only if the enable is active on the clock where it would rise. The number of pulses therefore equals the number of payload bits.
- R5: `tx_din` is captured on the clock edge where the payload clock becomes active, and that bit is sent during the following bit period.
- R6: Ready is inactive during the preamble. It is active from the first header bit until the end of the last payload bit, which is the end of the header when there is no payload.
- R7: After the last payload bit, or after the header if no bit was captured, `tx_bit` is 0 for exactly 2·`CLK_PER_US` clocks. Then `tx_on` falls.
- R8: A frame starts only when the block is armed. The block is armed out of reset and after at least ceil(2.22·`CLK_PER_US`) consecutive clocks of inactive enable. Starting a frame disarms it. Exactly one clock fewer than the threshold does not arm it.
- R9: `mod_rst` pulses high for one clock when the enable has been inactive for ceil(4.22·`CLK_PER_US`) consecutive clocks. One clock fewer gives no pulse.
- R10: Polarity register address 4 sets the active levels. Bit 0 makes ready active-low, bit 1 makes the enable active-low and bit 2 makes the payload clock active-low. When the block is idle, ready and the payload clock sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 signal, 1 service, 2 length low, 3 length high, 4 polarity) |
| cfg_wdata | input | 8 | Register write data |
| tx_en | input | 1 | Frame enable from the source, programmable polarity |
| tx_din | input | 1 | Serial payload from the source |
| tx_clk | output | 1 | Gated payload clock, programmable polarity |
| tx_rdy | output | 1 | Ready for payload, programmable polarity |
| tx_bit | output | 1 | Serial bit stream to the modulator |
| tx_on | output | 1 | High while a frame, including its flush, is being sent |
| mod_rst | output | 1 | One-clock modulator reset pulse after a long idle |

## Verification
Header serialization and payload intake share a cycle. The first payload bit is captured halfway through the last header bit, while the header bit is still on `tx_bit`, and the decision to enter payload or flush is made on the edge that ends that same bit. The bench drives frames of 0, 1, 2, 5 and 16 payload bits, including one where the enable drops before any clock pulse. It compares every sample of `tx_bit` against a stream it builds arithmetically from the register values, and it checks where the first clock pulse and the ready window fall. The idle timer is driven to one clock short of each threshold and then exactly to it.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
    localparam int HDR_BITS = 32;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_SIGNAL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_SERVICE = 3'd1;
    localparam logic [ADDR_W-1:0] A_LEN_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LEN_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_POLAR   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_PAY,
        ST_FLUSH
    } txf_state_e;

    typedef struct packed {
        logic rdy_low;
        logic en_low;
        logic clk_low;
    } txf_polar_t;
endpackage

// File: rtl/txf_cfg_regs.sv
module txf_cfg_regs
    import tx_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [HDR_BITS-1:0] hdr_word,
    output txf_polar_t        polar
);
    typedef struct packed {
        logic [7:0] sig;
        logic [7:0] svc;
        logic [7:0] len_lo;
        logic [7:0] len_hi;
        txf_polar_t pol;
    } cfg_t;

    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (addr)
                A_SIGNAL:  r_d.sig    = wdata;
                A_SERVICE: r_d.svc    = wdata;
                A_LEN_LO:  r_d.len_lo = wdata;
                A_LEN_HI:  r_d.len_hi = wdata;
                A_POLAR: begin
                    r_d.pol.rdy_low = wdata[0];
                    r_d.pol.en_low  = wdata[1];
                    r_d.pol.clk_low = wdata[2];
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Bit 0 of the word goes out first: signal, service, length low, length high.
    assign hdr_word = {r_q.len_hi, r_q.len_lo, r_q.svc, r_q.sig};
    assign polar    = r_q.pol;
endmodule

// File: rtl/txf_idle_timer.sv
module txf_idle_timer #(
    parameter int RESTART_CYC = 49,
    parameter int RESET_CYC   = 93
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_act,
    input  logic start,
    output logic armed,
    output logic mod_rst
);
    localparam int CNT_W = $clog2(RESET_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             arm;
        logic             mrst;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.mrst = 1'b0;
        if (en_act) begin
            t_d.cnt = '0;
        end else if (t_q.cnt != CNT_W'(RESET_CYC)) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
        if (start) begin
            t_d.arm = 1'b0;
        end else if (!en_act && t_q.cnt == CNT_W'(RESTART_CYC - 1)) begin
            t_d.arm = 1'b1;
        end
        if (!en_act && t_q.cnt == CNT_W'(RESET_CYC - 1)) begin
            t_d.mrst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt  <= CNT_W'(RESET_CYC);
            t_q.arm  <= 1'b1;
            t_q.mrst <= 1'b0;
        end else begin
            t_q <= t_d;
        end
    end

    assign armed   = t_q.arm;
    assign mod_rst = t_q.mrst;

    // R8: the sequencer may only launch a frame while armed
    assert_start_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> t_q.arm);

    // R9: a reset pulse follows a clock with the enable inactive
    assert_mrst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.mrst |-> $past(!en_act));

    // R9: the pulse lasts a single clock
    assert_mrst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.mrst |=> !t_q.mrst);
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tx_frame_pkg::*;
#(
    parameter int CLK_PER_US = 22,
    parameter int BIT_DIV    = 2,
    parameter int PRE_LEN    = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       tx_en,
    input  logic       tx_din,
    output logic       tx_clk,
    output logic       tx_rdy,
    output logic       tx_bit,
    output logic       tx_on,
    output logic       mod_rst
);
    localparam int RESTART_CYC = (222 * CLK_PER_US + 99) / 100;
    localparam int RESET_CYC   = (422 * CLK_PER_US + 99) / 100;
    localparam int FLUSH_CYC   = 2 * CLK_PER_US;
    localparam int HALF        = BIT_DIV / 2;
    localparam int MAX_IDX     = (PRE_LEN > HDR_BITS) ? PRE_LEN : HDR_BITS;
    localparam int IDX_W       = $clog2(MAX_IDX);
    localparam int PH_W        = $clog2(BIT_DIV);
    localparam int FL_W        = $clog2(FLUSH_CYC + 1);

    generate
        if (BIT_DIV < 2 || (BIT_DIV % 2) != 0) begin : g_bad_div
            $error("BIT_DIV must be even and at least 2");
        end
        if (CLK_PER_US < 1 || RESTART_CYC >= RESET_CYC) begin : g_bad_us
            $error("CLK_PER_US must give a restart threshold below the reset threshold");
        end
        if (PRE_LEN < 1) begin : g_bad_pre
            $error("PRE_LEN must be at least 1");
        end
    endgenerate

    typedef struct packed {
        txf_state_e       st;
        logic [PH_W-1:0]  ph;
        logic [IDX_W-1:0] idx;
        logic [FL_W-1:0]  fcnt;
        logic             pclk;
        logic             rdy;
        logic             got;
        logic             cap;
        logic             cur;
    } seq_t;

    seq_t s_d, s_q;

    logic [HDR_BITS-1:0] hdr_word;
    txf_polar_t          polar;
    logic                en_act, armed, start;
    logic                ph_last, ph_rise, window;

    txf_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .hdr_word (hdr_word),
        .polar    (polar)
    );

    assign en_act = tx_en ^ polar.en_low;

    txf_idle_timer #(
        .RESTART_CYC (RESTART_CYC),
        .RESET_CYC   (RESET_CYC)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_act  (en_act),
        .start   (start),
        .armed   (armed),
        .mod_rst (mod_rst)
    );

    assign ph_last = (s_q.ph == PH_W'(BIT_DIV - 1));
    assign ph_rise = (s_q.ph == PH_W'(HALF - 1));
    assign window  = (s_q.st == ST_PAY) ||
                     (s_q.st == ST_HDR && s_q.idx == IDX_W'(HDR_BITS - 1));

    always_comb begin
        s_d   = s_q;
        start = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (en_act && armed) begin
                    start   = 1'b1;
                    s_d.st  = ST_PRE;
                    s_d.ph  = '0;
                    s_d.idx = '0;
                end
            end
            ST_FLUSH: begin
                if (s_q.fcnt == FL_W'(FLUSH_CYC - 1)) begin
                    s_d.st   = ST_IDLE;
                    s_d.fcnt = '0;
                end else begin
                    s_d.fcnt = s_q.fcnt + 1'b1;
                end
            end
            default: begin
                s_d.ph = ph_last ? '0 : s_q.ph + 1'b1;
                if (window && ph_rise && en_act) begin
                    s_d.pclk = 1'b1;
                    s_d.got  = 1'b1;
                    s_d.cap  = tx_din;
                end
                if (ph_last) begin
                    s_d.pclk = 1'b0;
                    s_d.got  = 1'b0;
                    case (s_q.st)
                        ST_PRE: begin
                            if (s_q.idx == IDX_W'(PRE_LEN - 1)) begin
                                s_d.st  = ST_HDR;
                                s_d.idx = '0;
                                s_d.rdy = 1'b1;
                            end else begin
                                s_d.idx = s_q.idx + 1'b1;
                            end
                        end
                        ST_HDR: begin
                            if (s_q.idx != IDX_W'(HDR_BITS - 1)) begin
                                s_d.idx = s_q.idx + 1'b1;
                            end else if (s_q.got) begin
                                s_d.st  = ST_PAY;
                                s_d.cur = s_q.cap;
                            end else begin
                                s_d.st   = ST_FLUSH;
                                s_d.rdy  = 1'b0;
                                s_d.fcnt = '0;
                            end
                        end
                        default: begin
                            if (s_q.got) begin
                                s_d.cur = s_q.cap;
                            end else begin
                                s_d.st   = ST_FLUSH;
                                s_d.rdy  = 1'b0;
                                s_d.fcnt = '0;
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.st)
            ST_PRE:  tx_bit = 1'b1;
            ST_HDR:  tx_bit = hdr_word[s_q.idx[4:0]];
            ST_PAY:  tx_bit = s_q.cur;
            default: tx_bit = 1'b0;
        endcase
    end

    assign tx_on  = (s_q.st != ST_IDLE);
    assign tx_clk = s_q.pclk ^ polar.clk_low;
    assign tx_rdy = s_q.rdy ^ polar.rdy_low;

    // R1: an accepted start is followed by an active frame
    assert_start_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (tx_on && s_q.st == ST_PRE));

    // R4: payload clock pulses only inside the gating window states
    assert_clk_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pclk |-> (s_q.st == ST_HDR || s_q.st == ST_PAY));

    // R6: ready stays inactive while the preamble is sent
    assert_rdy_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PRE) |-> !s_q.rdy);

    // R7: a payload period with nothing captured leads into the flush
    assert_flush_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PAY && ph_last && !s_q.got) |=> (s_q.st == ST_FLUSH && !tx_bit));
endmodule

// File: tb/tb_tx_frame_seq.sv
`timescale 1ns/1ps
module tb_tx_frame_seq;
    localparam int CPU  = 50;
    localparam int BD   = 4;
    localparam int PRE  = 8;
    localparam int HDR  = 32;
    localparam int RST_A = (222 * CPU + 99) / 100;
    localparam int RST_M = (422 * CPU + 99) / 100;
    localparam int FLU  = 2 * CPU;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic tx_en = 1'b0, tx_din = 1'b0;
    logic tx_clk, tx_rdy, tx_bit, tx_on, mod_rst;

    int n_run = 0, n_fail = 0, pulses = 0;
    logic [2:0] pol_b = 3'b000;
    bit done = 0;

    always #10 clk = ~clk;

    tx_frame_seq #(.CLK_PER_US(CPU), .BIT_DIV(BD), .PRE_LEN(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_en(tx_en), .tx_din(tx_din),
        .tx_clk(tx_clk), .tx_rdy(tx_rdy), .tx_bit(tx_bit), .tx_on(tx_on),
        .mod_rst(mod_rst)
    );

    always @(negedge clk) if (mod_rst) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_en(input bit act);
        tx_en = act ^ pol_b[1];
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic load_hdr(input logic [7:0] sg, input logic [7:0] sv, input logic [15:0] ln);
        wr(3'd0, sg); wr(3'd1, sv); wr(3'd2, ln[7:0]); wr(3'd3, ln[15:8]);
    endtask

    task automatic hold_active(input int k);
        int ons = 0;
        set_en(1'b1);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (tx_on) ons++;
        end
        check(ons == 0, "R8 no start while disarmed", ons, 0);
    endtask

    task automatic drop(input int k);
        @(negedge clk);
        set_en(1'b0);
        pulses = 0;
        for (int i = 0; i < k; i++) @(negedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [7:0] sg, input logic [7:0] sv,
                              input logic [15:0] ln, input int n, input logic [31:0] pay);
        logic [31:0] hv;
        int ns = 0, rises = 0, first_rise = -1, rdy_cnt = 0, rdy_first = -1, k = 0;
        int bad_pre = 0, bad_hdr = 0, bad_pay = 0, bad_fl = 0;
        bit prev_clk = 0, fin = 0, ex, cn, rn;
        hv = {ln[15:8], ln[7:0], sv, sg};
        tx_din = pay[0];
        set_en(1'b1);
        for (int it = 0; it < 4000 && !fin; it++) begin
            @(negedge clk);
            if (it == 0) check(tx_on == 1'b1, "R1 tx_on after enable", tx_on, 1);
            if (tx_on) begin
                if (ns < PRE * BD) begin
                    if (tx_bit !== 1'b1) bad_pre++;
                end else if (ns < (PRE + HDR) * BD) begin
                    ex = hv[(ns / BD) - PRE];
                    if (tx_bit !== ex) bad_hdr++;
                end else if (ns < (PRE + HDR + n) * BD) begin
                    ex = pay[(ns / BD) - PRE - HDR];
                    if (tx_bit !== ex) bad_pay++;
                end else if (tx_bit !== 1'b0) bad_fl++;
                cn = tx_clk ^ pol_b[2];
                rn = tx_rdy ^ pol_b[0];
                if (rn) begin
                    rdy_cnt++;
                    if (rdy_first < 0) rdy_first = ns;
                end
                if (cn && !prev_clk) begin
                    rises++;
                    if (first_rise < 0) first_rise = ns;
                    k++;
                    if (k < n) tx_din = pay[k];
                    else set_en(1'b0);
                end
                prev_clk = cn;
                ns++;
            end else if (it > 0) begin
                fin = 1;
            end
            if (n == 0 && it == 0) set_en(1'b0);
        end
        check(bad_pre == 0, "R2 preamble ones", bad_pre, 0);
        check(bad_hdr == 0, "R3 header bit order", bad_hdr, 0);
        check(bad_pay == 0, "R5 payload capture and replay", bad_pay, 0);
        check(bad_fl == 0, "R7 flush bits zero", bad_fl, 0);
        check(ns == (PRE + HDR + n) * BD + FLU, "R7 frame length incl flush", ns, (PRE + HDR + n) * BD + FLU);
        check(rises == n, "R4 clock pulse count", rises, n);
        if (n > 0)
            check(first_rise == (PRE + HDR - 1) * BD + BD / 2, "R4 first pulse in last header bit",
                  first_rise, (PRE + HDR - 1) * BD + BD / 2);
        check(rdy_first == PRE * BD, "R6 ready start", rdy_first, PRE * BD);
        check(rdy_cnt == (HDR + n) * BD, "R6 ready span", rdy_cnt, (HDR + n) * BD);
        check(tx_rdy == pol_b[0] && tx_clk == pol_b[2], "R10 inactive levels after frame",
              {tx_rdy, tx_clk}, {pol_b[0], pol_b[2]});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_on == 0 && tx_bit == 0 && mod_rst == 0, "R1 reset idle", {tx_on, tx_bit, mod_rst}, 0);
        check(tx_rdy == 0 && tx_clk == 0, "R10 reset levels", {tx_rdy, tx_clk}, 0);

        load_hdr(8'h0A, 8'h04, 16'hA5C3);
        send_frame(8'h0A, 8'h04, 16'hA5C3, 5, 32'h0000_0016);

        hold_active(200);
        drop(RST_A - 1);
        check(pulses == 0, "R9 no pulse below threshold", pulses, 0);
        hold_active(10);

        load_hdr(8'h6E, 8'h81, 16'h0102);
        drop(RST_A);
        send_frame(8'h6E, 8'h81, 16'h0102, 1, 32'h0000_0001);

        hold_active(5);
        wr(3'd4, 8'h07);
        pol_b = 3'b111;
        hold_active(40);
        load_hdr(8'hFF, 8'h00, 16'h8001);
        drop(RST_M - 1);
        check(pulses == 0, "R9 one short of reset threshold", pulses, 0);
        check(tx_rdy == 1'b1 && tx_clk == 1'b1, "R10 active-low idle levels", {tx_rdy, tx_clk}, 3);
        send_frame(8'hFF, 8'h00, 16'h8001, 16, 32'h0000_C3A9);

        hold_active(50);
        load_hdr(8'h33, 8'hC8, 16'h7E10);
        drop(RST_M);
        check(pulses == 1, "R9 pulse at reset threshold", pulses, 1);
        send_frame(8'h33, 8'hC8, 16'h7E10, 0, 32'h0);

        send_frame(8'h33, 8'hC8, 16'h7E10, 2, 32'h0000_0002);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule